// File: doc/BRIEF.md
# Serial ADC Frame Master

This block is the host end of a four-wire serial link to a 12-bit sampling converter. While `run` is high it issues one conversion frame after another. Each frame holds the select line low for sixteen serial clocks. The block divides the system clock down to make the serial clock. On the first eight clocks it sends an 8-bit command byte built from the configuration inputs. Over all sixteen clocks it captures the returned word, then presents the 12-bit result with a one-cycle strobe.

The converter applies the channel written in one frame to the conversion it returns in the next frame. Each result is therefore tagged with the channel sent one frame earlier. The first result after reset is marked stale. The four leading bits of the returned word must be zero; the block checks them and flags an error if any is set. In dual-input mode an alternate option lets the block choose the channel itself, swapping it on every frame. A programmable idle gap, counted in system clocks, separates frames.

Top module: `adc_frame_master`

## Requirements
- R1: During a frame `ser_sel_n` stays low for exactly 16 rising edges of `ser_clk`. While `ser_sel_n` is high, `ser_clk` is low.
- R2: Each half period of `ser_clk` lasts `half_div` system clocks, with a value of 0 treated as 1. The first rising edge comes `half_div` clocks after `ser_sel_n` falls, and the last falling edge coincides with `ser_sel_n` rising.
- R3: The command byte goes out MSB first on the first eight rising edges. Its bit layout is:
  - bits 7, 6 and 2 are 0;
  - bit 5 is `cfg_ref_off | cfg_dual`;
  - bit 4 is `cfg_dual`;
  - bits 1:0 are `cfg_pm`.
- R4: Bit 3 of the command byte is the channel. It is 0 when `cfg_dual` is 0. In dual mode it is `cfg_chan` when `cfg_alt` is 0. In dual mode with `cfg_alt` at 1 it comes from a toggle that is 0 after reset and flips after every such frame.
- R5: `ser_mosi` changes only while `ser_clk` is low. It is 0 on rising edges 9 to 16 and whenever `ser_sel_n` is high.
- R6: `res_valid` pulses for one cycle in the same cycle that `ser_sel_n` rises. `res_data` then holds the last 12 bits captured from `ser_miso`, sampled on rising edges, MSB first.
- R7: `res_err` is 1 with a result exactly when any of the first four captured bits is 1.
- R8: `res_chan` is the channel bit sent in the frame before the one that just ended. It is 0 for the first frame after reset.
- R9: `res_stale` is 1 for the first result after reset and 0 for every later one.
- R10: Between frames `ser_sel_n` stays high for at least `gap_cycles`+1 system clocks. While `run` stays high it stays high for exactly that many.
- R11: While `run` is low no new frame starts. A frame already in progress runs to completion and delivers its result.
- R12: During reset and after it, `ser_sel_n` is 1 and `ser_clk`, `ser_mosi` and `res_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| run | input | 1 | Allow new frames to start |
| half_div | input | DIV_W | System clocks per serial-clock half period (0 acts as 1) |
| gap_cycles | input | GAP_W | Extra idle clocks between frames |
| cfg_ref_off | input | 1 | Request the converter's internal reference off |
| cfg_dual | input | 1 | Two-input mode |
| cfg_chan | input | 1 | Channel to request in dual mode |
| cfg_alt | input | 1 | Alternate channels automatically in dual mode |
| cfg_pm | input | 2 | Power mode field |
| ser_clk | output | 1 | Serial clock, idle low |
| ser_sel_n | output | 1 | Frame select, active low |
| ser_mosi | output | 1 | Command data to the converter |
| ser_miso | input | 1 | Conversion data from the converter |
| res_valid | output | 1 | One-cycle result strobe |
| res_data | output | 12 | Conversion result |
| res_chan | output | 1 | Channel that produced the result |
| res_stale | output | 1 | Result is the first one after reset |
| res_err | output | 1 | Leading bits of the returned word were not zero |

## Verification
The assertions assume that `half_div`, `gap_cycles` and the configuration inputs change only while `ser_sel_n` is high. They also assume `ser_miso` changes only while `ser_clk` is low. The bench keeps to this in two ways. It draws new random settings only in the cycle that `res_valid` is seen, which always falls inside the gap. Its converter model shifts the next bit out right after each falling edge of `ser_clk`. Its one change of `run` in the middle of a frame touches only the start of the next frame, so it breaks none of these assumptions.

// File: rtl/adc_fm_pkg.sv
// Package: shared constants and the command byte layout of the serial ADC frame master.
package adc_fm_pkg;
    localparam int FRAME_BITS = 16;
    localparam int CMD_BITS   = 8;
    localparam int RES_BITS   = 12;
    localparam int HDR_BITS   = FRAME_BITS - RES_BITS;
    localparam int CNT_W      = $clog2(FRAME_BITS);

    typedef enum logic {
        SEQ_GAP   = 1'b0,
        SEQ_FRAME = 1'b1
    } seq_state_t;

    // Command byte, MSB first on the wire; positions are decoded by the converter.
    typedef struct packed {
        logic       spare;    // bit 7, sent as 0
        logic       zero_hi;  // bit 6, must be 0
        logic       ref_off;  // bit 5
        logic       dual;     // bit 4
        logic       chan;     // bit 3
        logic       zero_lo;  // bit 2, must be 0
        logic [1:0] pm;       // bits 1:0
    } cmd_byte_t;
endpackage

// File: rtl/adc_fm_cmd.sv
// Module: builds the command byte from the configuration and keeps the
// auto-alternate channel toggle.
// Assumes: configuration is stable while a frame is loaded (st_load).
module adc_fm_cmd
    import adc_fm_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      st_load,
    input  logic      cfg_ref_off,
    input  logic      cfg_dual,
    input  logic      cfg_chan,
    input  logic      cfg_alt,
    input  logic [1:0] cfg_pm,
    output cmd_byte_t cmd,
    output logic      ch_sel
);
    logic alt_tog;

    // Channel choice: forced 0 in single mode, toggle or fixed in dual mode.
    always_comb begin
        if (!cfg_dual)
            ch_sel = 1'b0;
        else if (cfg_alt)
            ch_sel = alt_tog;
        else
            ch_sel = cfg_chan;
    end

    // Command byte assembly; dual mode forces the reference off.
    always_comb begin
        cmd.spare   = 1'b0;
        cmd.zero_hi = 1'b0;
        cmd.ref_off = cfg_ref_off | cfg_dual;
        cmd.dual    = cfg_dual;
        cmd.chan    = ch_sel;
        cmd.zero_lo = 1'b0;
        cmd.pm      = cfg_pm;
    end

    // Alternate toggle flips once per frame sent in dual alternate mode.
    always_ff @(posedge clk) begin
        if (!rst_n)
            alt_tog <= 1'b0;
        else if (st_load && cfg_dual && cfg_alt)
            alt_tog <= ~alt_tog;
    end
endmodule

// File: rtl/adc_fm_seq.sv
// Module: frame sequencer. Divides the system clock into the serial clock,
// holds select low for one frame and enforces the idle gap.
// Assumes: half_div and gap_cycles only change while select is high.
module adc_fm_seq
    import adc_fm_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    input  logic [GAP_W-1:0] gap_cycles,
    output logic             ser_clk,
    output logic             ser_sel_n,
    output logic             st_load,
    output logic             st_rise,
    output logic             st_fall,
    output logic             st_done
);
    seq_state_t       state;
    logic [DIV_W-1:0] half_cnt;
    logic [DIV_W-1:0] half_eff;
    logic [CNT_W-1:0] bit_cnt;
    logic [GAP_W-1:0] gap_cnt;
    logic             half_last;

    // Effective half period and end-of-half detection.
    always_comb begin
        half_eff  = (half_div == '0) ? DIV_W'(1) : half_div;
        half_last = (half_cnt == half_eff - DIV_W'(1));
    end

    // Strobes for the datapath: frame load, serial rising and falling edges, frame end.
    always_comb begin
        st_load = (state == SEQ_GAP) && (gap_cnt >= gap_cycles) && run;
        st_rise = (state == SEQ_FRAME) && half_last && !ser_clk;
        st_fall = (state == SEQ_FRAME) && half_last && ser_clk;
        st_done = st_fall && (bit_cnt == CNT_W'(FRAME_BITS - 1));
    end

    // Sequencer state, divider, bit counter and gap counter.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= SEQ_GAP;
            half_cnt  <= '0;
            bit_cnt   <= '0;
            gap_cnt   <= '0;
            ser_clk   <= 1'b0;
            ser_sel_n <= 1'b1;
        end else begin
            case (state)
                SEQ_GAP: begin
                    if (st_load) begin
                        state     <= SEQ_FRAME;
                        ser_sel_n <= 1'b0;
                        half_cnt  <= '0;
                        bit_cnt   <= '0;
                        ser_clk   <= 1'b0;
                    end else if (gap_cnt != '1) begin
                        gap_cnt <= gap_cnt + GAP_W'(1);
                    end
                end
                default: begin
                    if (half_last) begin
                        half_cnt <= '0;
                        ser_clk  <= ~ser_clk;
                        if (ser_clk) begin
                            bit_cnt <= bit_cnt + CNT_W'(1);
                            if (st_done) begin
                                state     <= SEQ_GAP;
                                ser_sel_n <= 1'b1;
                                gap_cnt   <= '0;
                            end
                        end
                    end else begin
                        half_cnt <= half_cnt + DIV_W'(1);
                    end
                end
            endcase
        end
    end
endmodule

// File: rtl/adc_fm_shift.sv
// Module: serial datapath. Shifts the command byte out, captures the returned
// word, tags results with the pipelined channel and flags stale or bad words.
// Assumes: strobes come from adc_fm_seq and are mutually consistent.
module adc_fm_shift
    import adc_fm_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                st_load,
    input  logic                st_rise,
    input  logic                st_fall,
    input  logic                st_done,
    input  cmd_byte_t           cmd,
    input  logic                ch_sel,
    input  logic                ser_miso,
    output logic                ser_mosi,
    output logic                res_valid,
    output logic [RES_BITS-1:0] res_data,
    output logic                res_chan,
    output logic                res_stale,
    output logic                res_err
);
    logic [CMD_BITS-1:0]   tx_sr;
    logic [FRAME_BITS-1:0] rx_sr;
    logic                  ch_now;
    logic                  ch_prev;
    logic                  first_now;
    logic                  seen_any;

    assign ser_mosi = tx_sr[CMD_BITS-1];

    // Transmit shifter: load at frame start, shift on falling serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            tx_sr <= '0;
        else if (st_load)
            tx_sr <= cmd;
        else if (st_fall)
            tx_sr <= {tx_sr[CMD_BITS-2:0], 1'b0};
    end

    // Receive shifter: capture the converter's bit on rising serial edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rx_sr <= '0;
        else if (st_load)
            rx_sr <= '0;
        else if (st_rise)
            rx_sr <= {rx_sr[FRAME_BITS-2:0], ser_miso};
    end

    // Channel pipeline and first-frame marker, advanced once per frame.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ch_now    <= 1'b0;
            ch_prev   <= 1'b0;
            first_now <= 1'b0;
            seen_any  <= 1'b0;
        end else if (st_load) begin
            ch_prev   <= ch_now;
            ch_now    <= ch_sel;
            first_now <= ~seen_any;
            seen_any  <= 1'b1;
        end
    end

    // Result register and one-cycle strobe at frame end.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_valid <= 1'b0;
            res_data  <= '0;
            res_chan  <= 1'b0;
            res_stale <= 1'b0;
            res_err   <= 1'b0;
        end else begin
            res_valid <= st_done;
            if (st_done) begin
                res_data  <= rx_sr[RES_BITS-1:0];
                res_err   <= |rx_sr[FRAME_BITS-1:RES_BITS];
                res_chan  <= ch_prev;
                res_stale <= first_now;
            end
        end
    end

    AST_FIXED_ZEROS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(st_load) |-> (tx_sr[7:6] == 2'b00 && !tx_sr[2])); // R3
    AST_SINGLE_CHAN: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(st_load) && !tx_sr[4]) |-> !tx_sr[3]); // R4
endmodule

// File: rtl/adc_frame_master.sv
// Module: top of the serial ADC frame master. Wires the sequencer, command
// builder and datapath; holds the cross-module assertions.
// Assumes: configuration, half_div and gap_cycles change only between frames.
module adc_frame_master
    import adc_fm_pkg::*;
#(
    parameter int DIV_W = 8,
    parameter int GAP_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] half_div,
    input  logic [GAP_W-1:0] gap_cycles,
    input  logic             cfg_ref_off,
    input  logic             cfg_dual,
    input  logic             cfg_chan,
    input  logic             cfg_alt,
    input  logic [1:0]       cfg_pm,
    output logic             ser_clk,
    output logic             ser_sel_n,
    output logic             ser_mosi,
    input  logic             ser_miso,
    output logic             res_valid,
    output logic [11:0]      res_data,
    output logic             res_chan,
    output logic             res_stale,
    output logic             res_err
);
    logic      st_load, st_rise, st_fall, st_done;
    cmd_byte_t cmd;
    logic      ch_sel;

    adc_fm_seq #(.DIV_W(DIV_W), .GAP_W(GAP_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
        .gap_cycles(gap_cycles), .ser_clk(ser_clk), .ser_sel_n(ser_sel_n),
        .st_load(st_load), .st_rise(st_rise), .st_fall(st_fall), .st_done(st_done)
    );

    adc_fm_cmd u_cmd (
        .clk(clk), .rst_n(rst_n), .st_load(st_load), .cfg_ref_off(cfg_ref_off),
        .cfg_dual(cfg_dual), .cfg_chan(cfg_chan), .cfg_alt(cfg_alt),
        .cfg_pm(cfg_pm), .cmd(cmd), .ch_sel(ch_sel)
    );

    adc_fm_shift u_shift (
        .clk(clk), .rst_n(rst_n), .st_load(st_load), .st_rise(st_rise),
        .st_fall(st_fall), .st_done(st_done), .cmd(cmd), .ch_sel(ch_sel),
        .ser_miso(ser_miso), .ser_mosi(ser_mosi), .res_valid(res_valid),
        .res_data(res_data), .res_chan(res_chan), .res_stale(res_stale),
        .res_err(res_err)
    );

    // Checker counters: serial rising edges per frame and select-high run length.
    logic [CNT_W:0] rise_cnt;
    logic [GAP_W:0] hi_cnt;

    always_ff @(posedge clk) begin
        if (!rst_n)
            rise_cnt <= '0;
        else if (st_load)
            rise_cnt <= '0;
        else if (st_rise)
            rise_cnt <= rise_cnt + (CNT_W+1)'(1);
    end

    always_ff @(posedge clk) begin
        if (!rst_n)
            hi_cnt <= '0;
        else if (!ser_sel_n)
            hi_cnt <= '0;
        else if (hi_cnt != '1)
            hi_cnt <= hi_cnt + (GAP_W+1)'(1);
    end

    AST_CLK_IDLE_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_n |-> !ser_clk); // R1
    AST_SIXTEEN_RISES: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(ser_sel_n) |-> (rise_cnt == (CNT_W+1)'(FRAME_BITS))); // R1
    AST_MOSI_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
        (ser_clk && !ser_sel_n) |-> $stable(ser_mosi)); // R5
    AST_MOSI_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        ser_sel_n |-> !ser_mosi); // R5
    AST_VALID_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |-> $rose(ser_sel_n)); // R6
    AST_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        res_valid |=> !res_valid); // R6
    AST_GAP_MIN: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(ser_sel_n) |-> (hi_cnt > {1'b0, gap_cycles})); // R10
endmodule

// File: tb/tb_adc_frame_master.sv
// Bench: random and directed settings, a converter model on the serial pins,
// and a monitor that checks every frame against values computed from the requirements.
module tb_adc_frame_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        run = 1'b0;
    logic [7:0]  half_div = 8'd2;
    logic [7:0]  gap_cycles = 8'd3;
    logic        cfg_ref_off = 1'b0, cfg_dual = 1'b0, cfg_chan = 1'b0, cfg_alt = 1'b0;
    logic [1:0]  cfg_pm = 2'b00;
    logic        ser_clk, ser_sel_n, ser_mosi;
    logic        ser_miso = 1'b0;
    logic        res_valid, res_chan, res_stale, res_err;
    logic [11:0] res_data;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;

    adc_frame_master dut (
        .clk(clk), .rst_n(rst_n), .run(run), .half_div(half_div),
        .gap_cycles(gap_cycles), .cfg_ref_off(cfg_ref_off), .cfg_dual(cfg_dual),
        .cfg_chan(cfg_chan), .cfg_alt(cfg_alt), .cfg_pm(cfg_pm),
        .ser_clk(ser_clk), .ser_sel_n(ser_sel_n), .ser_mosi(ser_mosi),
        .ser_miso(ser_miso), .res_valid(res_valid), .res_data(res_data),
        .res_chan(res_chan), .res_stale(res_stale), .res_err(res_err)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Expected command byte from R3 and R4.
    function automatic logic [7:0] want_byte(input logic ref_off, input logic dual,
                                             input logic ch, input logic [1:0] pm);
        return {2'b00, ref_off | dual, dual, ch, 1'b0, pm};
    endfunction

    // Model state kept by the monitor.
    logic        prev_cs = 1'b1, prev_sclk = 1'b0;
    int          ev_cnt, rises, bi, hi_len, heff, frames, valids;
    bit          hp_bad, tail_bad, have_prev, run_steady;
    logic [7:0]  rx_byte, exp_b;
    logic [15:0] word;
    logic        m_tog, m_cur, m_seen, exp_chan, exp_stale, chn;

    // Converter model and frame monitor, sampled on the falling system clock edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_cs = 1'b1; prev_sclk = 1'b0; m_tog = 0; m_cur = 0; m_seen = 0;
            have_prev = 0; hi_len = 0; ser_miso = 0;
        end else begin
            if (prev_cs && !ser_sel_n) begin
                frames++;
                if (have_prev && run_steady)
                    check(hi_len == gap_cycles + 1, "R10 gap length", hi_len, gap_cycles + 1);
                heff = (half_div == 0) ? 1 : half_div;
                ev_cnt = 0; hp_bad = 0; rises = 0; rx_byte = 0; tail_bad = 0;
                case (frames)
                    1: word = 16'h0FFF;
                    2: word = 16'h0000;
                    3: word = 16'h0800;
                    4: word = 16'hF001;
                    default: begin
                        word = 16'($urandom);
                        if ($urandom % 4 != 0) word[15:12] = 4'h0;
                    end
                endcase
                bi = 15; ser_miso = word[15];
                chn = cfg_dual ? (cfg_alt ? m_tog : cfg_chan) : 1'b0;
                if (cfg_dual && cfg_alt) m_tog = ~m_tog;
                exp_b = want_byte(cfg_ref_off, cfg_dual, chn, cfg_pm);
                exp_chan = m_cur; m_cur = chn;
                exp_stale = !m_seen; m_seen = 1;
            end else if (!prev_cs) begin
                ev_cnt++;
                if (ser_clk != prev_sclk || ser_sel_n) begin
                    if (ev_cnt != heff) hp_bad = 1;
                    ev_cnt = 0;
                end
                if (!prev_sclk && ser_clk) begin
                    rises++;
                    if (rises <= 8) rx_byte = {rx_byte[6:0], ser_mosi};
                    else if (ser_mosi) tail_bad = 1;
                end
                if (prev_sclk && !ser_clk && !ser_sel_n && bi > 0) begin
                    bi--; ser_miso = word[bi];
                end
                if (ser_sel_n) begin
                    hi_len = 1; have_prev = 1; ser_miso = 0;
                    check(rises == 16, "R1 rising edges per frame", rises, 16);
                    check(!hp_bad, "R2 half period", heff, heff);
                    check({rx_byte[7:4], rx_byte[2:0]} == {exp_b[7:4], exp_b[2:0]},
                          "R3 command byte", rx_byte, exp_b);
                    check(rx_byte[3] == exp_b[3], "R4 channel bit", rx_byte[3], exp_b[3]);
                    check(!tail_bad, "R5 mosi after byte", 1, 0);
                    check(res_valid, "R6 strobe at frame end", res_valid, 1);
                    if (res_valid) begin
                        check(res_data == word[11:0], "R6 result data", res_data, word[11:0]);
                        check(res_err == (|word[15:12]), "R7 header error", res_err, |word[15:12]);
                        check(res_chan == exp_chan, "R8 result channel", res_chan, exp_chan);
                        check(res_stale == exp_stale, "R9 stale flag", res_stale, exp_stale);
                    end
                end
            end else begin
                hi_len++;
            end
            if (res_valid) valids++;
            if (res_valid && !(prev_cs == 1'b0 && ser_sel_n))
                check(0, "R6 strobe outside frame end", 1, 0);
            if (ser_sel_n && (ser_clk || ser_mosi))
                check(0, "R1 R5 idle lines", {ser_clk, ser_mosi}, 0);
            prev_cs = ser_sel_n; prev_sclk = ser_clk;
        end
    end

    task automatic wait_valid();
        do @(negedge clk); while (!res_valid);
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(ser_sel_n && !ser_clk && !ser_mosi && !res_valid, "R12 reset state",
              {ser_sel_n, ser_clk, ser_mosi, res_valid}, 4'b1000);
        rst_n = 1'b1;
        repeat (2) @(negedge clk);
        check(ser_sel_n && !ser_clk && !res_valid, "R12 after reset",
              {ser_sel_n, ser_clk, res_valid}, 3'b100);
    endtask

    initial begin : main
        int base_f, base_v;
        void'($urandom(32'd4242));
        run_steady = 1;
        do_reset();
        // Directed: dual alternate mode, reference request off (R4 toggle, R3 forced bit 5).
        cfg_dual = 1; cfg_alt = 1; cfg_pm = 2'b10;
        run = 1;
        repeat (4) wait_valid();
        // Directed: single mode with channel requested high (R4 forced 0), fastest timing.
        cfg_dual = 0; cfg_alt = 0; cfg_chan = 1; cfg_ref_off = 0; half_div = 0; gap_cycles = 0;
        repeat (2) wait_valid();
        // Random settings, changed only at the result strobe.
        for (int i = 0; i < 200; i++) begin
            wait_valid();
            half_div = 8'($urandom % 5); gap_cycles = 8'($urandom % 8);
            cfg_ref_off = $urandom % 2; cfg_dual = $urandom % 2; cfg_chan = $urandom % 2;
            cfg_alt = $urandom % 2; cfg_pm = 2'($urandom % 4);
        end
        // R11: drop run in the middle of a frame; the frame must still finish.
        do @(negedge clk); while (ser_sel_n);
        repeat (10) @(negedge clk);
        run_steady = 0; run = 0;
        base_v = valids;
        repeat (200) @(negedge clk);
        check(valids == base_v + 1, "R11 frame completes after run drop", valids - base_v, 1);
        base_f = frames;
        repeat (200) @(negedge clk);
        check(frames == base_f && ser_sel_n, "R11 no frame while run low", frames - base_f, 0);
        // Second reset, then the first result must be stale again (R9, R12).
        do_reset();
        half_div = 3; gap_cycles = 5; cfg_dual = 1; cfg_alt = 0; cfg_chan = 1;
        run = 1;
        wait_valid();
        run_steady = 1;
        repeat (4) wait_valid();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++; checks++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule